// File: doc/BRIEF.md
# Vector length control register

This block keeps the vector length state of a scalar core whose element loops run in hardware. It answers CSR accesses aimed at two addresses. The first is a length register with its own write rule. A swap access asks for a length, the block limits it to the maximum vector length (MVL), stores it, and returns the stored value to the destination register. It does not return the previous value. The second is a loop-state register that packs the length together with the sub-vector length and the saved loop positions. It follows ordinary CSR rules, so one swap both saves and restores a context.

Each request is taken on a clock edge when `req_valid` is high. The block then answers one cycle later on `rsp_valid`/`rsp_data`. The current length, the sub-vector length and the fixed MVL are always visible on dedicated outputs. A length of 1 is plain scalar operation, and the sub-vector length stays in force in that mode.

Top module: `vl_ctrl`

## Requirements
- R1: After reset the length is 1, the sub-vector length is 1, both saved offsets are 0, `rsp_valid` is 0 and `rsp_data` is 0.
- R2: A swap (`req_op`=0) from a register operand to address `ADDR_VL` sets the length to the operand, limited to the range 1..MVL. One cycle after the request, `rsp_valid` is 1 and `rsp_data` holds that new length.
- R3: A register operand of 0 on a length swap is taken as 1, so the length is never 0.
- R4: A requested length above MVL, including values with high operand bits set, gives exactly MVL. A request equal to MVL is kept as it is.
- R5: In immediate form (`req_use_imm`=1) a length swap requests the 5-bit immediate plus one (0..31 means 1..32). That value is still limited to MVL.
- R6: A set (`req_op`=1) or clear (`req_op`=2) access to `ADDR_VL` leaves all state unchanged and returns the current length.
- R7: The loop-state register at `ADDR_ST` reads as: bits [5:0] length−1, bits [7:6] sub-vector length−1, bits [13:8] saved element offset, bits [15:14] saved sub-element offset, and upper bits 0. A swap returns the old contents and loads the operand's low 16 bits into the fields.
- R8: Set and clear on `ADDR_ST` OR in, or clear, the operand bits and return the old contents. In immediate form the operand is the immediate zero-extended.
- R9: A length field written through `ADDR_ST` whose value plus one exceeds MVL leaves the length at MVL.
- R10: A request with `req_valid` low, `req_op`=3, or any other address gives no response and changes no state.
- R11: Setting the length to 1 (or any value) through `ADDR_VL` leaves the sub-vector length and the saved offsets unchanged.
- R12: `mvl_o` always shows the MVL parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | CSR address |
| req_op | input | 2 | 0 swap, 1 set bits, 2 clear bits, 3 no access |
| req_use_imm | input | 1 | Operand taken from `req_imm` instead of `req_rs_val` |
| req_imm | input | 5 | Immediate operand |
| req_rs_val | input | XLEN | Register operand |
| rsp_valid | output | 1 | Destination value valid (one cycle after request) |
| rsp_data | output | XLEN | Value for the destination register |
| vl_o | output | 7 | Current vector length |
| mvl_o | output | 7 | Maximum vector length |
| subvl_o | output | 3 | Current sub-vector length (1..4) |

## Verification
The length is driven with in-range values, zero, exactly MVL, and values above MVL with both low and high operand bits set. This separates the zero fix-up, the limit and a plain truncation of the operand. Immediate swaps at 0, a mid value and 31 show the plus-one encoding. Loop-state swaps, sets and clears with distinct bit patterns in each field check the field layout and that the old value comes back. Length swaps made right after a loop-state write show that the sub-vector fields survive. Misses on address, operation code and strobe are placed between real requests so that a leaked write or response would be seen.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  localparam int VL_W = 7;
  localparam int ST_W = 16;

  typedef enum logic [1:0] {
    OP_SWAP = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } csr_op_e;

  // Limit a requested length to 1..lim
  function automatic logic [VL_W-1:0] clamp_len(input logic [63:0] req,
                                                 input logic [VL_W-1:0] lim);
    if (req == 64'd0) return VL_W'(1);
    if (req > 64'(lim)) return lim;
    return VL_W'(req);
  endfunction

  // Ordinary CSR read-modify-write
  function automatic logic [ST_W-1:0] apply_op(input csr_op_e op,
                                                input logic [ST_W-1:0] old,
                                                input logic [ST_W-1:0] opnd);
    case (op)
      OP_SWAP: return opnd;
      OP_SET:  return old | opnd;
      OP_CLR:  return old & ~opnd;
      default: return old;
    endcase
  endfunction
endpackage

// File: rtl/vlc_decode.sv
module vlc_decode
  import vlc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_VL = 12'hC20,
  parameter logic [ADDR_W-1:0] ADDR_ST = 12'hC21
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  csr_op_e           op,
  output logic              vl_swap,
  output logic              vl_keep,
  output logic              st_acc,
  output logic              hit
);
  logic active;
  always_comb begin
    active  = valid && (op != OP_NONE);
    vl_swap = active && (addr == ADDR_VL) && (op == OP_SWAP);
    vl_keep = active && (addr == ADDR_VL) && (op != OP_SWAP);
    st_acc  = active && (addr == ADDR_ST);
    hit     = vl_swap || vl_keep || st_acc;
  end
endmodule

// File: rtl/vlc_regs.sv
module vlc_regs
  import vlc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int MVL  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vl_swap,
  input  logic            st_acc,
  input  csr_op_e         op,
  input  logic            use_imm,
  input  logic [4:0]      imm,
  input  logic [XLEN-1:0] rs_val,
  output logic [VL_W-1:0] vl_q,
  output logic [2:0]      subvl,
  output logic [ST_W-1:0] st_view,
  output logic [VL_W-1:0] swap_len
);
  localparam logic [VL_W-1:0] MVL_V = VL_W'(MVL);

  logic [1:0]      subm1_q;
  logic [5:0]      eoff_q;
  logic [1:0]      soff_q;
  logic [63:0]     req_raw;
  logic [ST_W-1:0] opnd;
  logic [ST_W-1:0] st_new;
  logic [VL_W-1:0] st_len;
  logic [5:0]      vlm1;

  always_comb begin
    req_raw  = use_imm ? (64'(imm) + 64'd1) : 64'(rs_val);
    swap_len = clamp_len(req_raw, MVL_V);
    vlm1     = 6'(vl_q - VL_W'(1));
    st_view  = {soff_q, eoff_q, subm1_q, vlm1};
    opnd     = use_imm ? ST_W'(imm) : rs_val[ST_W-1:0];
    st_new   = apply_op(op, st_view, opnd);
    st_len   = clamp_len(64'(st_new[5:0]) + 64'd1, MVL_V);
    subvl    = {1'b0, subm1_q} + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl_q    <= VL_W'(1);
      subm1_q <= 2'd0;
      eoff_q  <= 6'd0;
      soff_q  <= 2'd0;
    end else if (vl_swap) begin
      vl_q <= swap_len;
    end else if (st_acc) begin
      vl_q    <= st_len;
      subm1_q <= st_new[7:6];
      eoff_q  <= st_new[13:8];
      soff_q  <= st_new[15:14];
    end
  end

  // R4 / R3: the stored length always stays within 1..MVL
  a_r4_vl_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (vl_q >= VL_W'(1)) && (vl_q <= MVL_V));

  // R11: a length swap leaves the loop-state fields alone
  a_r11_subvl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    vl_swap |=> ($stable(subm1_q) && $stable(eoff_q) && $stable(soff_q)));

  // R6 / R10: without a length swap or loop-state access the length holds
  a_r6_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!vl_swap && !st_acc) |=> $stable(vl_q));
endmodule

// File: rtl/vl_ctrl.sv
module vl_ctrl
  import vlc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int MVL  = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_VL = 12'hC20,
  parameter logic [ADDR_W-1:0] ADDR_ST = 12'hC21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_op,
  input  logic              req_use_imm,
  input  logic [4:0]        req_imm,
  input  logic [XLEN-1:0]   req_rs_val,
  output logic              rsp_valid,
  output logic [XLEN-1:0]   rsp_data,
  output logic [VL_W-1:0]   vl_o,
  output logic [VL_W-1:0]   mvl_o,
  output logic [2:0]        subvl_o
);
  csr_op_e         op;
  logic            ev_vl_swap;
  logic            ev_vl_keep;
  logic            ev_st_acc;
  logic            ev_hit;
  logic [VL_W-1:0] vl_q;
  logic [ST_W-1:0] st_view;
  logic [VL_W-1:0] swap_len;
  logic            rsp_from_swap_q;
  logic [XLEN-1:0] rsp_next;

  assign op = csr_op_e'(req_op);

  vlc_decode #(.ADDR_W(ADDR_W), .ADDR_VL(ADDR_VL), .ADDR_ST(ADDR_ST)) u_decode (
    .valid   (req_valid),
    .addr    (req_addr),
    .op      (op),
    .vl_swap (ev_vl_swap),
    .vl_keep (ev_vl_keep),
    .st_acc  (ev_st_acc),
    .hit     (ev_hit)
  );

  vlc_regs #(.XLEN(XLEN), .MVL(MVL)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .vl_swap  (ev_vl_swap),
    .st_acc   (ev_st_acc),
    .op       (op),
    .use_imm  (req_use_imm),
    .imm      (req_imm),
    .rs_val   (req_rs_val),
    .vl_q     (vl_q),
    .subvl    (subvl_o),
    .st_view  (st_view),
    .swap_len (swap_len)
  );

  always_comb begin
    if (ev_vl_swap)      rsp_next = XLEN'(swap_len);
    else if (ev_vl_keep) rsp_next = XLEN'(vl_q);
    else if (ev_st_acc)  rsp_next = XLEN'(st_view);
    else                 rsp_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid       <= 1'b0;
      rsp_data        <= '0;
      rsp_from_swap_q <= 1'b0;
    end else begin
      rsp_valid       <= ev_hit;
      rsp_data        <= rsp_next;
      rsp_from_swap_q <= ev_vl_swap;
    end
  end

  assign vl_o  = vl_q;
  assign mvl_o = VL_W'(MVL);

  // R2: a length swap hands back the length now in force
  a_r2_returns_new: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_from_swap_q) |-> (rsp_data == XLEN'(vl_o)));

  // R10: no response follows a request that matched nothing
  a_r10_no_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_hit |=> !rsp_valid);
endmodule

// File: tb/vl_ctrl_bench.sv
module vl_ctrl_bench;
  localparam int XLEN = 32;
  localparam int MVL  = 32;
  localparam logic [11:0] A_VL = 12'hC20;
  localparam logic [11:0] A_ST = 12'hC21;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_op = 2'd0;
  logic        req_use_imm = 1'b0;
  logic [4:0]  req_imm = '0;
  logic [31:0] req_rs_val = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [6:0]  vl_o, mvl_o;
  logic [2:0]  subvl_o;

  int n_checks = 0;
  int n_fail = 0;

  // reference model state
  int m_vl = 1, m_sub = 1, m_eo = 0, m_so = 0;
  int e_rv = 0;
  longint e_rd = 0;

  always #10 clk = ~clk;

  vl_ctrl u_vl_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_op(req_op), .req_use_imm(req_use_imm), .req_imm(req_imm),
    .req_rs_val(req_rs_val), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .vl_o(vl_o), .mvl_o(mvl_o), .subvl_o(subvl_o)
  );

  function automatic int lim(longint r);
    if (r == 0) return 1;
    if (r > MVL) return MVL;
    return int'(r);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_vl = 1; m_sub = 1; m_eo = 0; m_so = 0; e_rv = 0; e_rd = 0;
    end else begin
      e_rv = 0; e_rd = 0;
      if (req_valid && req_op != 2'd3) begin
        if (req_addr == A_VL) begin
          e_rv = 1;
          if (req_op == 2'd0) begin
            m_vl = lim(req_use_imm ? longint'(req_imm) + 1 : longint'(req_rs_val));
          end
          e_rd = m_vl;
        end else if (req_addr == A_ST) begin
          longint old, opd, nw;
          old = (m_vl - 1) + (m_sub - 1) * 64 + m_eo * 256 + m_so * 16384;
          opd = req_use_imm ? longint'(req_imm) : (longint'(req_rs_val) % 65536);
          if (req_op == 2'd0) nw = opd;
          else if (req_op == 2'd1) nw = old | opd;
          else nw = old & ~opd & 65535;
          m_vl  = lim((nw % 64) + 1);
          m_sub = int'((nw / 64) % 4) + 1;
          m_eo  = int'((nw / 256) % 64);
          m_so  = int'((nw / 16384) % 4);
          e_rv = 1; e_rd = old;
        end
      end
    end
  end

  task automatic compare(input string tag);
    bit bad;
    bad = (vl_o != 7'(m_vl)) || (subvl_o != 3'(m_sub)) || (mvl_o != 7'(MVL)) ||
          (rsp_valid != 1'(e_rv)) || (rsp_data != 32'(e_rd));
    n_checks++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s: vl=%0d sub=%0d mvl=%0d rv=%0d rd=%0h expected vl=%0d sub=%0d mvl=%0d rv=%0d rd=%0h",
               tag, vl_o, subvl_o, mvl_o, rsp_valid, rsp_data, m_vl, m_sub, MVL, e_rv, e_rd);
    end
  endtask

  task automatic req(input string tag, input logic v, input logic [11:0] a,
                     input logic [1:0] op, input logic ui, input logic [4:0] im,
                     input logic [31:0] rs);
    @(negedge clk);
    req_valid = v; req_addr = a; req_op = op; req_use_imm = ui;
    req_imm = im; req_rs_val = rs;
    @(negedge clk);
    req_valid = 1'b0;
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");
    req("R7 read state after reset", 1, A_ST, 2'd1, 0, 5'd0, 32'd0);
    req("R12 idle mvl", 0, A_VL, 2'd0, 0, 5'd0, 32'd0);
    req("R2 rs=5", 1, A_VL, 2'd0, 0, 5'd0, 32'd5);
    req("R2 rs=17", 1, A_VL, 2'd0, 0, 5'd0, 32'd17);
    req("R3 rs=0", 1, A_VL, 2'd0, 0, 5'd0, 32'd0);
    req("R4 rs=MVL", 1, A_VL, 2'd0, 0, 5'd0, 32'd32);
    req("R4 rs=33", 1, A_VL, 2'd0, 0, 5'd0, 32'd33);
    req("R4 rs=100", 1, A_VL, 2'd0, 0, 5'd0, 32'd100);
    req("R4 rs=high bits", 1, A_VL, 2'd0, 0, 5'd0, 32'h8000_0003);
    req("R4 rs=all ones", 1, A_VL, 2'd0, 0, 5'd0, 32'hFFFF_FFFF);
    req("R5 imm=0", 1, A_VL, 2'd0, 1, 5'd0, 32'd9);
    req("R5 imm=7", 1, A_VL, 2'd0, 1, 5'd7, 32'd0);
    req("R5 imm=31", 1, A_VL, 2'd0, 1, 5'd31, 32'd0);
    req("R2 rs=12", 1, A_VL, 2'd0, 0, 5'd0, 32'd12);
    req("R6 set on length", 1, A_VL, 2'd1, 0, 5'd0, 32'hFF);
    req("R6 clear on length", 1, A_VL, 2'd2, 1, 5'd31, 32'hFF);
    req("R7 swap state", 1, A_ST, 2'd0, 0, 5'd0, 32'hABCD_9A84);
    req("R7 swap state back", 1, A_ST, 2'd0, 0, 5'd0, 32'h0000_4E43);
    req("R8 set state imm", 1, A_ST, 2'd1, 1, 5'd5, 32'hFFFF);
    req("R8 set state rs", 1, A_ST, 2'd1, 0, 5'd0, 32'h0000_8040);
    req("R8 clear state rs", 1, A_ST, 2'd2, 0, 5'd0, 32'h0000_0C07);
    req("R8 clear state imm", 1, A_ST, 2'd2, 1, 5'd2, 32'd0);
    req("R9 state len field 63", 1, A_ST, 2'd0, 0, 5'd0, 32'h0000_C0FF);
    req("R9 state len field 32", 1, A_ST, 2'd0, 0, 5'd0, 32'h0000_0060);
    req("R9 readback", 1, A_ST, 2'd1, 0, 5'd0, 32'd0);
    req("R11 len=1 keeps sub", 1, A_VL, 2'd0, 0, 5'd0, 32'd1);
    req("R11 state intact", 1, A_ST, 2'd1, 0, 5'd0, 32'd0);
    req("R11 imm len keeps sub", 1, A_VL, 2'd0, 1, 5'd9, 32'd0);
    req("R10 other address", 1, 12'hC22, 2'd0, 0, 5'd0, 32'd3);
    req("R10 op 3 length", 1, A_VL, 2'd3, 0, 5'd0, 32'd4);
    req("R10 op 3 state", 1, A_ST, 2'd3, 0, 5'd0, 32'h0);
    req("R10 valid low", 0, A_VL, 2'd0, 0, 5'd0, 32'd2);
    req("R10 state unchanged", 1, A_ST, 2'd1, 0, 5'd0, 32'd0);
    req("R12 idle end", 0, A_ST, 2'd0, 0, 5'd0, 32'd0);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    compare("R1 second reset");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule